// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs the timing for an external successive-approximation converter. Software drives it through one write-only control word. Each write sets the enable, the channel, the sync mode and the start request. The block then steps through its phases. After enable, it waits for the reference to settle. After a start, it lets the selected input settle. If sync is enabled, it holds until an external trigger arrives. Finally it converts, and each phase has a fixed length in clock cycles.

A behavioural converter inside the block captures the analog input word when conversion begins. It hands that value back as a 10-bit result with a valid flag that software polls. Completing a conversion also raises a one-cycle interrupt pulse for the chip's interrupt collector. Clearing the enable at any time drops the block back to the powered-down state.

Top module: `adc_seq`

## Requirements
- R1: After reset, `busy`, `result_valid` and `done_irq` are all low.
- R2: Control word fields: bit 0 is enable, bit 1 is start, bit 2 is sync-enable, and bits [CH_W+2:3] are the channel. `mux_sel` shows the channel of the latest write from the next cycle on.
- R3: A write that sets enable while the block is powered down starts a reference settle of REF_CYC cycles. A start that arrives during the settle is held. Its result becomes valid REF_CYC+SEL_CYC+CONV_CYC clock edges after the enabling write.
- R4: A start written while the block is enabled and idle makes `busy` high from the next cycle. `result_valid` rises SEL_CYC+CONV_CYC edges after the start write.
- R5: Any write with enable and start both set clears `result_valid` on the next cycle.
- R6: With sync-enable set, the block waits after the select settle for as long as `sync_in` stays low. `result_valid` rises CONV_CYC edges after the edge that first samples `sync_in` high in that wait.
- R7: `result` equals the value of `ana_in` at the edge where conversion begins. Later changes of `ana_in` do not alter it.
- R8: `done_irq` is high for exactly one cycle, and that is the cycle in which `result_valid` rises.
- R9: A write with enable clear aborts any phase on the next cycle, with `busy` and `result_valid` low. The next enable then needs a full reference settle again.
- R10: A start written while a conversion is in progress restarts from the select settle. The result is valid SEL_CYC+CONV_CYC edges after the latest start.
- R11: A write with enable set while the block is already enabled does not repeat the reference settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | CH_W+3 | Control word |
| sync_in | input | 1 | External conversion trigger |
| ana_in | input | DATA_W | Analog level presented by the front-end model |
| mux_sel | output | CH_W | Channel driven to the input multiplexer |
| busy | output | 1 | Select settle, sync wait or conversion in progress |
| result | output | DATA_W | Conversion result |
| result_valid | output | 1 | Result is ready |
| done_irq | output | 1 | One-cycle conversion-complete pulse |

## Verification
Each result has a fixed delay counted from the edge that samples the stimulus. The result is due REF_CYC+SEL_CYC+CONV_CYC edges after an enabling write and SEL_CYC+CONV_CYC edges after a start in the idle state. After a sync trigger it is due CONV_CYC edges later. The status and channel outputs follow after one edge. The bench counts clock edges and stamps each write with the number of the edge that samples it. It drives inputs and samples outputs on the falling edge, and measures each latency as the difference of edge numbers. A timestamp-driven reference model also predicts every output each cycle and is compared on every falling edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // Control word bit positions (software-visible layout)
   localparam int unsigned CW_EN   = 0;
   localparam int unsigned CW_GO   = 1;
   localparam int unsigned CW_SYNC = 2;
   localparam int unsigned CW_CHAN = 3;

   typedef enum logic [2:0] {
      PH_OFF  = 3'd0,
      PH_REF  = 3'd1,
      PH_RDY  = 3'd2,
      PH_SEL  = 3'd3,
      PH_WAIT = 3'd4,
      PH_CONV = 3'd5
   } phase_t;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W+2:0]   wr_data,
   output logic              cmd_on,
   output logic              cmd_off,
   output logic              cmd_go,
   output logic              sync_en_q,
   output logic [CH_W-1:0]   chan_q
);
   always_comb begin
      cmd_on  = wr_en &  wr_data[CW_EN];
      cmd_off = wr_en & ~wr_data[CW_EN];
      cmd_go  = wr_en &  wr_data[CW_EN] & wr_data[CW_GO];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_en_q <= 1'b0;
         chan_q    <= '0;
      end else if (wr_en) begin
         sync_en_q <= wr_data[CW_SYNC];
         chan_q    <= wr_data[CW_CHAN +: CH_W];
      end
   end
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
   import adc_seq_pkg::*;
#(
   parameter int unsigned REF_CYC   = 250,
   parameter int unsigned SEL_CYC   = 51,
   parameter int unsigned CONV_CYC  = 102,
   parameter int unsigned SYNC_EDGE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_on,
   input  logic cmd_off,
   input  logic cmd_go,
   input  logic sync_en,
   input  logic sync_in,
   output logic busy,
   output logic smp_go,
   output logic conv_done,
   output logic clr_valid
);
   localparam int unsigned MAX_A  = (REF_CYC > SEL_CYC) ? REF_CYC : SEL_CYC;
   localparam int unsigned MAX_C  = (MAX_A > CONV_CYC) ? MAX_A : CONV_CYC;
   localparam int unsigned CNT_W  = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] REF_LD  = CNT_W'(REF_CYC - 1);
   localparam logic [CNT_W-1:0] SEL_LD  = CNT_W'(SEL_CYC - 1);
   localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);

   phase_t           ph, ph_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             pend, pend_n;
   logic             sync_hit;

   generate
      if (SYNC_EDGE != 0) begin : g_sync_edge
         logic sync_d;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_d <= 1'b0;
            else        sync_d <= sync_in;
         end
         assign sync_hit = sync_in & ~sync_d;
      end else begin : g_sync_level
         assign sync_hit = sync_in;
      end
   endgenerate

   always_comb begin
      ph_n      = ph;
      cnt_n     = (cnt != '0) ? cnt - 1'b1 : cnt;
      pend_n    = pend;
      smp_go    = 1'b0;
      conv_done = 1'b0;
      if (ph == PH_OFF) begin
         if (cmd_on) begin
            ph_n   = PH_REF;
            cnt_n  = REF_LD;
            pend_n = cmd_go;
         end
      end else if (cmd_off) begin
         ph_n   = PH_OFF;
         cnt_n  = '0;
         pend_n = 1'b0;
      end else begin
         unique case (ph)
            PH_REF: begin
               if (cnt == '0) begin
                  if (pend | cmd_go) begin
                     ph_n   = PH_SEL;
                     cnt_n  = SEL_LD;
                     pend_n = 1'b0;
                  end else begin
                     ph_n = PH_RDY;
                  end
               end else if (cmd_go) begin
                  pend_n = 1'b1;
               end
            end
            PH_RDY: begin
               if (cmd_go) begin
                  ph_n  = PH_SEL;
                  cnt_n = SEL_LD;
               end
            end
            PH_SEL: begin
               if (cmd_go) begin
                  cnt_n = SEL_LD;
               end else if (cnt == '0) begin
                  if (sync_en) begin
                     ph_n = PH_WAIT;
                  end else begin
                     ph_n   = PH_CONV;
                     cnt_n  = CONV_LD;
                     smp_go = 1'b1;
                  end
               end
            end
            PH_WAIT: begin
               if (cmd_go) begin
                  ph_n  = PH_SEL;
                  cnt_n = SEL_LD;
               end else if (sync_hit) begin
                  ph_n   = PH_CONV;
                  cnt_n  = CONV_LD;
                  smp_go = 1'b1;
               end
            end
            PH_CONV: begin
               if (cmd_go) begin
                  ph_n  = PH_SEL;
                  cnt_n = SEL_LD;
               end else if (cnt == '0) begin
                  ph_n      = PH_RDY;
                  conv_done = 1'b1;
               end
            end
            default: ph_n = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph   <= PH_OFF;
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         ph   <= ph_n;
         cnt  <= cnt_n;
         pend <= pend_n;
      end
   end

   assign clr_valid = cmd_off | cmd_go;
   assign busy      = (ph == PH_SEL) | (ph == PH_WAIT) | (ph == PH_CONV);
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ana_in,
   input  logic              smp_go,
   input  logic              conv_done,
   input  logic              clr_valid,
   output logic [DATA_W-1:0] result,
   output logic              result_valid,
   output logic              done_irq
);
   logic [DATA_W-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held         <= '0;
         result       <= '0;
         result_valid <= 1'b0;
         done_irq     <= 1'b0;
      end else begin
         if (smp_go) held <= ana_in;
         if (conv_done) begin
            result       <= held;
            result_valid <= 1'b1;
         end else if (clr_valid) begin
            result_valid <= 1'b0;
         end
         done_irq <= conv_done;
      end
   end
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
   parameter int unsigned DATA_W    = 10,
   parameter int unsigned CH_W      = 3,
   parameter int unsigned REF_CYC   = 250,
   parameter int unsigned SEL_CYC   = 51,
   parameter int unsigned CONV_CYC  = 102,
   parameter int unsigned SYNC_EDGE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W+2:0]   wr_data,
   input  logic              sync_in,
   input  logic [DATA_W-1:0] ana_in,
   output logic [CH_W-1:0]   mux_sel,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic              result_valid,
   output logic              done_irq
);
   generate
      if (DATA_W < 1 || CH_W < 1) begin : g_bad_width
         $error("adc_seq: DATA_W and CH_W must be at least 1");
      end
      if (REF_CYC < 1 || SEL_CYC < 1 || CONV_CYC < 1) begin : g_bad_timing
         $error("adc_seq: every phase needs at least one cycle");
      end
      if (SYNC_EDGE > 1) begin : g_bad_sync
         $error("adc_seq: SYNC_EDGE must be 0 or 1");
      end
   endgenerate

   logic cmd_on, cmd_off, cmd_go, sync_en_q;
   logic smp_go, conv_done, clr_valid;

   adc_ctrl_reg #(.CH_W(CH_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .cmd_on    (cmd_on),
      .cmd_off   (cmd_off),
      .cmd_go    (cmd_go),
      .sync_en_q (sync_en_q),
      .chan_q    (mux_sel)
   );

   adc_phase_seq #(
      .REF_CYC   (REF_CYC),
      .SEL_CYC   (SEL_CYC),
      .CONV_CYC  (CONV_CYC),
      .SYNC_EDGE (SYNC_EDGE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_on    (cmd_on),
      .cmd_off   (cmd_off),
      .cmd_go    (cmd_go),
      .sync_en   (sync_en_q),
      .sync_in   (sync_in),
      .busy      (busy),
      .smp_go    (smp_go),
      .conv_done (conv_done),
      .clr_valid (clr_valid)
   );

   adc_conv_model #(.DATA_W(DATA_W)) u_conv (
      .clk          (clk),
      .rst_n        (rst_n),
      .ana_in       (ana_in),
      .smp_go       (smp_go),
      .conv_done    (conv_done),
      .clr_valid    (clr_valid),
      .result       (result),
      .result_valid (result_valid),
      .done_irq     (done_irq)
   );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W     = 3,
   parameter int unsigned SEL_CYC  = 51,
   parameter int unsigned CONV_CYC = 102
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [CH_W+2:0] wr_data,
   input logic            busy,
   input logic            result_valid,
   input logic            done_irq
);
   localparam int unsigned MIN_LAT = SEL_CYC + CONV_CYC;
   int unsigned since_go;

   always_ff @(posedge clk) begin
      if (!rst_n) since_go <= 0;
      else if (wr_en && wr_data[CW_EN] && wr_data[CW_GO]) since_go <= 0;
      else if (since_go < MIN_LAT + 1) since_go <= since_go + 1;
   end

   p_irq_has_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> result_valid);
   p_rise_has_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_valid) |-> done_irq);
   p_irq_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[CW_EN]) |=> (!busy && !result_valid));
   p_go_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CW_EN] && wr_data[CW_GO]) |=> !result_valid);
   p_min_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> (since_go >= MIN_LAT));
endmodule

bind adc_seq adc_seq_chk #(
   .CH_W     (CH_W),
   .SEL_CYC  (SEL_CYC),
   .CONV_CYC (CONV_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .busy         (busy),
   .result_valid (result_valid),
   .done_irq     (done_irq)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
   localparam int DATA_W = 10;
   localparam int CH_W   = 3;
   localparam int REF    = 250;
   localparam int SEL    = 51;
   localparam int CONV   = 102;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [CH_W+2:0]   wr_data = '0;
   logic              sync_in = 1'b0;
   logic [DATA_W-1:0] ana_in = '0;
   logic [CH_W-1:0]   mux_sel;
   logic              busy, result_valid, done_irq;
   logic [DATA_W-1:0] result;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   adc_seq #(
      .DATA_W(DATA_W), .CH_W(CH_W), .REF_CYC(REF), .SEL_CYC(SEL), .CONV_CYC(CONV), .SYNC_EDGE(0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sync_in(sync_in),
      .ana_in(ana_in), .mux_sel(mux_sel), .busy(busy), .result(result),
      .result_valid(result_valid), .done_irq(done_irq)
   );

   // reference model: phases with absolute deadline edges
   int m_ph = 0;   // 0 off,1 settle,2 idle,3 select,4 wait,5 convert
   int m_until = 0;
   bit m_pend = 0, m_valid = 0, m_irq = 0, m_sync = 0;
   int m_chan = 0, m_samp = 0, m_res = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         m_ph = 0; m_pend = 0; m_valid = 0; m_irq = 0; m_sync = 0; m_chan = 0;
      end else begin
         bit w_en, w_go;
         w_en = wr_data[0];
         w_go = wr_data[1];
         m_irq = 0;
         if (wr_en && !w_en) begin
            m_ph = 0; m_valid = 0; m_pend = 0;
         end else if (wr_en && w_en && m_ph == 0) begin
            m_ph = 1; m_until = cyc + REF; m_pend = w_go;
         end else begin
            if (m_ph == 1 && cyc == m_until) begin
               if (m_pend) begin m_ph = 3; m_until = cyc + SEL; m_pend = 0; end
               else m_ph = 2;
            end else if (m_ph == 3 && cyc == m_until) begin
               if (m_sync) m_ph = 4;
               else begin m_ph = 5; m_until = cyc + CONV; m_samp = ana_in; end
            end else if (m_ph == 4 && sync_in) begin
               m_ph = 5; m_until = cyc + CONV; m_samp = ana_in;
            end else if (m_ph == 5 && cyc == m_until && !(wr_en && w_go)) begin
               m_ph = 2; m_valid = 1; m_res = m_samp; m_irq = 1;
            end
            if (wr_en && w_go) begin
               m_valid = 0;
               if (m_ph == 1) m_pend = 1;
               else begin m_ph = 3; m_until = cyc + SEL; end
            end
         end
         if (wr_en) begin
            m_sync = wr_data[2];
            m_chan = wr_data[CH_W+2:3];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at edge %0d", req, act, exp, cyc);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (m_ph >= 3), {cur_req, "/R4 busy"}, busy, m_ph >= 3);
         chk(result_valid == m_valid, {cur_req, "/R5 valid"}, result_valid, m_valid);
         chk(done_irq == m_irq, {cur_req, "/R8 irq"}, done_irq, m_irq);
         chk(int'(mux_sel) == m_chan, {cur_req, "/R2 channel"}, mux_sel, m_chan);
         if (m_valid) chk(int'(result) == m_res, {cur_req, "/R7 result"}, result, m_res);
      end
   end

   task automatic wr(input bit en, input bit go, input bit sy, input int ch, output int edge_no);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = {CH_W'(ch), sy, go, en};
      edge_no = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_valid(output int at_edge);
      int guard = 0;
      while (!result_valid && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      at_edge = cyc;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      int e, e2, v, d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk(!busy && !result_valid && !done_irq, "R1", {busy, result_valid, done_irq}, 0);

      // R2 / R3: enable, then start while the reference settles
      cur_req = "R3";
      ana_in = 10'h2A5;
      wr(1, 0, 0, 5, e);
      chk(mux_sel == 3'd5, "R2", mux_sel, 5);
      repeat (10) @(negedge clk);
      wr(1, 1, 0, 5, d);
      chk(!busy, "R3", busy, 0);
      wait_valid(v);
      chk(v - e == REF + SEL + CONV, "R3", v - e, REF + SEL + CONV);
      chk(result == 10'h2A5, "R7", result, 10'h2A5);

      // R11 / R4 / R5 / R8
      cur_req = "R4";
      wr(1, 0, 0, 2, d);
      chk(result_valid, "R11", result_valid, 1);
      wr(1, 1, 0, 2, e);
      chk(!result_valid, "R5", result_valid, 0);
      chk(busy, "R4", busy, 1);
      wait_valid(v);
      chk(v - e == SEL + CONV, "R11", v - e, SEL + CONV);
      chk(done_irq, "R8", done_irq, 1);
      @(negedge clk);
      chk(!done_irq && result_valid, "R8", done_irq, 0);

      // R7: input changes during conversion are ignored
      cur_req = "R7";
      ana_in = 10'h155;
      wr(1, 1, 0, 4, e);
      repeat (SEL + 5) @(negedge clk);
      ana_in = 10'h0AA;
      wait_valid(v);
      chk(result == 10'h155, "R7", result, 10'h155);

      // R6: sync-gated conversion
      cur_req = "R6";
      wr(1, 1, 1, 3, e);
      repeat (SEL + 40) @(negedge clk);
      chk(busy && !result_valid, "R6", {busy, result_valid}, 2);
      sync_in = 1'b1;
      e2 = cyc + 1;
      @(negedge clk);
      sync_in = 1'b0;
      wait_valid(v);
      chk(v - e2 == CONV, "R6", v - e2, CONV);
      wr(1, 0, 0, 3, d);

      // R10: restart during conversion
      cur_req = "R10";
      wr(1, 1, 0, 1, e);
      repeat (SEL + 20) @(negedge clk);
      wr(1, 1, 0, 1, e2);
      wait_valid(v);
      chk(v - e2 == SEL + CONV, "R10", v - e2, SEL + CONV);

      // R9: abort and re-enable
      cur_req = "R9";
      wr(1, 1, 0, 6, e);
      repeat (40) @(negedge clk);
      wr(0, 0, 0, 6, d);
      chk(!busy && !result_valid, "R9", {busy, result_valid}, 0);
      repeat (5) @(negedge clk);
      wr(1, 1, 0, 6, e2);
      wait_valid(v);
      chk(v - e2 == REF + SEL + CONV, "R9", v - e2, REF + SEL + CONV);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule